// File: doc/BRIEF.md
# Single-Level Translation Table Walker

This block services a translation-buffer miss by fetching one entry from a flat translation table in main memory. A miss request carries a 20-bit virtual page number. The table's start address comes from a dedicated base register input. The walker multiplies the page number by four, adds it to the base, and issues a single word read through a request/ready handshake. It then waits for the read-valid strobe and inspects the valid flag of the returned word.

A set flag produces a one-cycle refill pulse for the translation buffer. The pulse carries the walked virtual page number, the 18-bit physical page number and the entry's attribute bits. A clear flag produces a one-cycle fault pulse instead. A physical address is then formed as `{ppn, offset}`: a 30-bit value in which the 12 offset bits pass through unchanged. Only one walk is in flight at a time. `busy` tells the requester when a new miss can be accepted.

The controller has four states. In IDLE a miss is accepted (transition *accept*). In ISSUE the read request is held until it is granted (transition *granted*). In AWAIT the walker waits for read data (transition *data*). CHECK is a single cycle that emits the refill or fault pulse (transition *retire*) and then returns to IDLE.

Top module: `pt_walker`

## Requirements
- R1: After reset `busy`, `mem_req`, `refill_valid` and `fault` are all 0.
- R2: The read address is `(table_base + miss_vpn*4) mod 2^30`, using the values of `table_base` and `miss_vpn` in the accepting cycle. Later changes to either input do not alter `mem_addr` for that walk.
- R3: `mem_req` rises the cycle after acceptance and stays high with a stable `mem_addr` until a cycle in which `mem_ready` is 1. It then drops, and it is not raised again during the same walk, so each walk makes exactly one read.
- R4: After the grant the walker waits any number of cycles for `mem_rvalid`. `mem_rdata` is ignored in every cycle where `mem_rvalid` is 0.
- R5: Entry layout: bit 31 is the valid flag, bits 30..18 are attribute bits and bits 17..0 are the physical page number. If bit 31 is 1, `refill_valid` pulses for exactly one cycle, the cycle after the data beat. During that pulse `res_ppn` equals entry[17:0], `res_attr` equals entry[30:18], `res_vpn` equals the walked page number, and `fault` is 0.
- R6: If bit 31 is 0, `fault` pulses for exactly one cycle, the cycle after the data beat. During that pulse `res_vpn` equals the walked page number and `refill_valid` is 0.
- R7: `busy` is 1 from the cycle after acceptance through the pulse cycle, and 0 otherwise. A miss is accepted only when `busy` is 0. `miss_valid` asserted while `busy` is 1 starts no walk.
- R8: After a refill or fault pulse the walker is idle and accepts a new miss in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Miss request present |
| miss_vpn | input | 20 | Virtual page number to resolve |
| table_base | input | 30 | Physical start address of the translation table |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Read request to memory |
| mem_addr | output | 30 | Read address (entry address) |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data (table entry) |
| refill_valid | output | 1 | One-cycle refill pulse |
| fault | output | 1 | One-cycle page-fault pulse |
| res_vpn | output | 20 | Page number of the finished walk |
| res_ppn | output | 18 | Physical page number for the refill |
| res_attr | output | 13 | Entry attribute bits for the refill |

## Verification
Most internal faults in this block surface at the ports within a few cycles. A wrong latched address appears on `mem_addr` in the first ISSUE cycle. A controller that leaves ISSUE early drops `mem_req` before a grant. A controller that leaves AWAIT early, or that samples unqualified data, yields a wrong valid decision or wrong page number in the pulse cycle right after the data beat. A state that fails to return to IDLE shows as `busy` staying high, or as a pulse lasting more than one cycle, on the cycle after the pulse. Sweeping the grant delay and the response delay exposes each of these at a known cycle.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
    localparam int VPN_W   = 20;
    localparam int PPN_W   = 18;
    localparam int PA_W    = 30;
    localparam int ENTRY_W = 32;
    localparam int VLD_BIT = ENTRY_W - 1;
    localparam int ATTR_W  = VLD_BIT - PPN_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_AWAIT = 2'd2,
        ST_CHECK = 2'd3
    } walk_state_t;
endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
    parameter int IDX_W  = 20,
    parameter int ADDR_W = 30,
    parameter int SHIFT  = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  index,
    output logic [ADDR_W-1:0] addr
);
    localparam int PAD_W = ADDR_W - IDX_W - SHIFT;

    logic [ADDR_W-1:0] scaled;

    always_comb begin
        scaled = {{PAD_W{1'b0}}, index, {SHIFT{1'b0}}};
        addr   = base + scaled;
    end
endmodule

// File: rtl/pt_entry_decode.sv
module pt_entry_decode #(
    parameter int ENT_W  = 32,
    parameter int FRM_W  = 18
) (
    input  logic [ENT_W-1:0]         entry,
    output logic                     present,
    output logic [ENT_W-FRM_W-2:0]   attr,
    output logic [FRM_W-1:0]         frame
);
    always_comb begin
        present = entry[ENT_W-1];
        attr    = entry[ENT_W-2:FRM_W];
        frame   = entry[FRM_W-1:0];
    end
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
    import pt_walker_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic miss_valid,
    input  logic mem_ready,
    input  logic mem_rvalid,
    input  logic entry_present,
    output logic take_miss,
    output logic take_data,
    output logic busy,
    output logic mem_req,
    output logic refill_valid,
    output logic fault
);
    walk_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d      = state_q;
        take_miss    = 1'b0;
        take_data    = 1'b0;
        busy         = 1'b1;
        mem_req      = 1'b0;
        refill_valid = 1'b0;
        fault        = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                if (miss_valid) begin
                    take_miss = 1'b1;
                    state_d   = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                mem_req = 1'b1;
                if (mem_ready) state_d = ST_AWAIT;
            end
            ST_AWAIT: begin
                if (mem_rvalid) begin
                    take_data = 1'b1;
                    state_d   = ST_CHECK;
                end
            end
            ST_CHECK: begin
                refill_valid = entry_present;
                fault        = !entry_present;
                state_d      = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(refill_valid && fault)); // R5
    AST_RESULT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_valid || fault) |=> !(refill_valid || fault)); // R6
    AST_IDLE_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_valid || fault) |=> (!busy && !mem_req)); // R8
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [VPN_W-1:0]  miss_vpn,
    input  logic [PA_W-1:0]   table_base,
    output logic              busy,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [ENTRY_W-1:0] mem_rdata,
    output logic              refill_valid,
    output logic              fault,
    output logic [VPN_W-1:0]  res_vpn,
    output logic [PPN_W-1:0]  res_ppn,
    output logic [ATTR_W-1:0] res_attr
);
    logic              take_miss, take_data, present;
    logic [PA_W-1:0]   addr_calc, addr_q;
    logic [VPN_W-1:0]  vpn_q;
    logic [ENTRY_W-1:0] entry_q;

    pt_addr_gen #(.IDX_W(VPN_W), .ADDR_W(PA_W), .SHIFT(2)) u_addr (
        .base  (table_base),
        .index (miss_vpn),
        .addr  (addr_calc)
    );

    pt_entry_decode #(.ENT_W(ENTRY_W), .FRM_W(PPN_W)) u_dec (
        .entry   (entry_q),
        .present (present),
        .attr    (res_attr),
        .frame   (res_ppn)
    );

    pt_walk_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .miss_valid    (miss_valid),
        .mem_ready     (mem_ready),
        .mem_rvalid    (mem_rvalid),
        .entry_present (present),
        .take_miss     (take_miss),
        .take_data     (take_data),
        .busy          (busy),
        .mem_req       (mem_req),
        .refill_valid  (refill_valid),
        .fault         (fault)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            vpn_q   <= '0;
            entry_q <= '0;
        end else begin
            if (take_miss) begin
                addr_q <= addr_calc;
                vpn_q  <= miss_vpn;
            end
            if (take_data) entry_q <= mem_rdata;
        end
    end

    assign mem_addr = addr_q;
    assign res_vpn  = vpn_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr))); // R3
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> !mem_req); // R3
    AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R7
    AST_PULSE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_valid || fault) |-> busy); // R7
    AST_ACCEPT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && miss_valid) |=> (busy && mem_req)); // R2
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid = 1'b0;
    logic [19:0] miss_vpn = '0;
    logic [29:0] table_base = '0;
    logic        busy, mem_req, mem_ready = 1'b0, mem_rvalid = 1'b0;
    logic [29:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        refill_valid, fault;
    logic [19:0] res_vpn;
    logic [17:0] res_ppn;
    logic [12:0] res_attr;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_vpn(miss_vpn),
        .table_base(table_base), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .refill_valid(refill_valid), .fault(fault), .res_vpn(res_vpn),
        .res_ppn(res_ppn), .res_attr(res_attr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic walk(input logic [19:0] vpn, input logic [29:0] base,
                        input logic [31:0] entry, input int gnt_dly, input int rsp_dly);
        logic [29:0] exp_addr;
        exp_addr = base + {8'd0, vpn, 2'b00};
        miss_valid = 1'b1; miss_vpn = vpn; table_base = base;
        @(negedge clk);
        miss_valid = 1'b0;
        miss_vpn   = ~vpn;
        table_base = ~base;
        chk(busy == 1'b1, "R7 busy after accept", {31'd0, busy}, 32'd1);
        chk(mem_req == 1'b1, "R3 req rises", {31'd0, mem_req}, 32'd1);
        chk(mem_addr == exp_addr, "R2 entry address", {2'd0, mem_addr}, {2'd0, exp_addr});
        for (int k = 0; k < gnt_dly; k++) begin
            miss_valid = 1'b1;
            @(negedge clk);
            chk(mem_req == 1'b1 && mem_addr == exp_addr, "R3 req held",
                {2'd0, mem_addr}, {2'd0, exp_addr});
        end
        miss_valid = 1'b0;
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
        for (int k = 0; k < rsp_dly; k++) begin
            mem_rdata = ~entry;
            @(negedge clk);
            chk(!mem_req && busy && !refill_valid && !fault, "R4 waiting",
                {28'd0, mem_req, busy, refill_valid, fault}, 32'h4);
        end
        chk(!mem_req, "R3 single read", {31'd0, mem_req}, 32'd0);
        mem_rvalid = 1'b1; mem_rdata = entry;
        @(negedge clk);
        mem_rvalid = 1'b0; mem_rdata = ~entry;
        miss_valid = 1'b1;
        if (entry[31]) begin
            chk(refill_valid && !fault, "R5 refill pulse",
                {30'd0, refill_valid, fault}, 32'h2);
            chk(res_ppn == entry[17:0], "R5 ppn", {14'd0, res_ppn}, {14'd0, entry[17:0]});
            chk(res_attr == entry[30:18], "R5 attr", {19'd0, res_attr}, {19'd0, entry[30:18]});
            chk(res_vpn == vpn, "R5 vpn", {12'd0, res_vpn}, {12'd0, vpn});
        end else begin
            chk(fault && !refill_valid, "R6 fault pulse",
                {30'd0, refill_valid, fault}, 32'h1);
            chk(res_vpn == vpn, "R6 vpn", {12'd0, res_vpn}, {12'd0, vpn});
        end
        chk(busy == 1'b1, "R7 busy in pulse", {31'd0, busy}, 32'd1);
        @(negedge clk);
        miss_valid = 1'b0;
        chk(!busy && !mem_req && !refill_valid && !fault, "R7 miss while busy ignored / R8 idle",
            {28'd0, busy, mem_req, refill_valid, fault}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req && !refill_valid && !fault, "R1 reset state",
            {28'd0, busy, mem_req, refill_valid, fault}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req, "R1 after release", {30'd0, busy, mem_req}, 32'd0);
        for (int i = 0; i < 96; i++) begin
            logic [19:0] v;
            logic [29:0] b;
            logic [31:0] e;
            v = 20'((i * 32'h9E37) ^ (i << 13));
            if (i == 1) v = 20'hFFFFF;
            if (i == 2) v = 20'h00000;
            b = 30'((i * 32'h01357ACC) & 32'h3FFF_FFFC);
            if (i % 7 == 3) b = 30'h3FFF_FFFC;
            e = {(i % 3) != 0, 13'((i * 97) ^ 13'h1555), 18'((v * 7) + i)};
            walk(v, b, e, i % 4, (i / 4) % 4);
        end
        // R8: back-to-back miss accepted immediately after a pulse
        miss_valid = 1'b1; miss_vpn = 20'h00ABC; table_base = 30'h100;
        @(negedge clk);
        miss_valid = 1'b0;
        chk(busy && mem_req && mem_addr == 30'h100 + 30'h2AF0, "R8 immediate accept",
            {2'd0, mem_addr}, 32'h100 + 32'h2AF0);
        mem_ready = 1'b1; @(negedge clk); mem_ready = 1'b0;
        mem_rvalid = 1'b1; mem_rdata = 32'h8000_0005; @(negedge clk); mem_rvalid = 1'b0;
        chk(refill_valid && res_ppn == 18'h5, "R5 short walk", {14'd0, res_ppn}, 32'h5);
        @(negedge clk);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule